// File: doc/BRIEF.md
# Dual-Channel Serial LCD Segment and Scan Driver Core

This block is the digital core of a serial-loaded LCD driver. It has two channels of 20 outputs each. Each channel holds a shift register and a latch bank. The shift register moves in one of two directions, chosen by a per-channel direction input. The data pin on the entry side takes serial data. The pin on the far side carries the bit at the far end of the register, so several drivers can be chained. For each output, the block produces a 2-bit level code. One bit picks the selected or the non-selected reference pair, from the latched bit. The other bit picks which level of that pair is driven, from the alternation signal M.

The two driver strobes, the shift strobe and the latch strobe, are sampled on the system clock, and the block acts on their edges. In normal mode, both channels shift on a falling shift-strobe edge and latch on a falling latch-strobe edge. When the bypass input is high, channel 2 becomes a scan-line driver. It shifts on a rising latch-strobe edge, latches on a rising shift-strobe edge, and drives the inverted alternation signal. A single frame-start bit fed into channel 2 then walks along the scan outputs. Generating the analog levels is outside this block.

Top module: `lcd_serial_drv`

## Requirements
- R1: A synchronous active-high reset clears every shift register and latch. After reset, every code has pair-select bit 0, and its polarity bit follows that channel's polarity rule (R6).
- R2: The direction input chooses the shift direction of its channel.
  - dir=1: the left pin is the input, and a new bit enters index 0 and moves toward index 19.
  - dir=0: the right pin is the input, and a new bit enters index 19 and moves toward index 0.
- R3: With bypass low, each falling edge of the shift strobe shifts both channels by exactly one position. Without a shift event, a register holds its value.
- R4: With bypass low, a falling edge of the latch strobe copies each channel's shift register into its latch bank. Between latch events, the pair-select bits do not change.
- R5: With bypass high, channel 2 shifts on a rising latch-strobe edge and latches on a rising shift-strobe edge. Falling edges have no effect on channel 2. Channel 1 keeps its normal-mode behaviour.
- R6: Output i of a channel is the code pair {code[2i+1], code[2i]}.
  - code[2i+1] is the latched bit: 1 selects the selected pair, 0 selects the channel's own non-selected pair.
  - code[2i] is the polarity. For channel 1 it equals M. For channel 2 it equals M when bypass is low and the inverse of M when bypass is high.
- R7: Each channel has two cascade pins and two output-enable flags.
  - dir=1: the right pin is enabled as the output and shows register bit 19.
  - dir=0: the left pin is enabled and shows register bit 0.
  - In both cases, the pin shows the bit that leaves on the next shift.
- R8: In scan mode, feeding one 1 followed by zeros into channel 2 and running shift-then-latch cycles gives exactly one selected channel-2 output after each of the first 20 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk_i | input | 1 | Shift strobe level |
| latch_clk_i | input | 1 | Latch strobe level |
| m_i | input | 1 | Alternation signal |
| bypass_i | input | 1 | 1 = channel 2 in scan-line mode |
| dir_i | input | 2 | Per-channel direction, bit c for channel c+1 |
| left_i | input | 2 | Left data pin input value per channel |
| right_i | input | 2 | Right data pin input value per channel |
| left_o | output | 2 | Left data pin cascade value per channel |
| right_o | output | 2 | Right data pin cascade value per channel |
| left_oe_o | output | 2 | Left pin drives output |
| right_oe_o | output | 2 | Right pin drives output |
| ch1_code_o | output | 40 | Channel 1 level codes, two bits per output |
| ch2_code_o | output | 40 | Channel 2 level codes, two bits per output |

## Verification
The assertions check the following on every cycle:
- each shift moves the register by one place in the chosen direction and takes in the entry pin;
- the register holds without a shift event;
- the latch takes in the register on a load event and holds otherwise;
- in bypass mode, a falling shift-strobe edge leaves the channel-2 latch unchanged.

Only the bench's scenarios can show the rest:
- the mapping of strobe edges to channels in each mode;
- the inverted polarity of channel 2;
- the cascade pin roles;
- the single walking scan bit.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    localparam int unsigned CH_OUTS = 20;
    localparam int unsigned NUM_CH  = 2;

    typedef enum logic {
        DIR_RL = 1'b0,
        DIR_LR = 1'b1
    } shift_dir_e;

    // strobe vector bit positions
    localparam int unsigned STB_SHIFT = 0;
    localparam int unsigned STB_LATCH = 1;
    localparam int unsigned STB_W     = 2;

    typedef struct packed {
        logic shift;
        logic load;
        logic pol_inv;
    } ch_ctl_t;

    typedef struct packed {
        logic pair_sel;
        logic pol;
    } lvl_code_t;

    function automatic lvl_code_t encode_level(logic sel_bit, logic pol);
        lvl_code_t c;
        c.pair_sel = sel_bit;
        c.pol      = pol;
        return c;
    endfunction

endpackage

// File: rtl/lcd_edge_det.sv
module lcd_edge_det #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    // reset loads the live level so a strobe held high gives no false edge
    always_ff @(posedge clk) begin
        if (rst) prev_q <= sig_i;
        else     prev_q <= sig_i;
    end

    assign rise_o = sig_i & ~prev_q;
    assign fall_o = ~sig_i & prev_q;

endmodule

// File: rtl/lcd_shift_reg.sv
module lcd_shift_reg
    import lcd_drv_pkg::*;
#(
    parameter int unsigned N = CH_OUTS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic         dir_i,
    input  logic         left_i,
    input  logic         right_i,
    output logic [N-1:0] q_o,
    output logic         left_o,
    output logic         right_o,
    output logic         left_oe_o,
    output logic         right_oe_o
);
    logic [N-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (step_i) begin
            if (dir_i == DIR_LR) q <= {q[N-2:0], left_i};
            else                 q <= {right_i, q[N-1:1]};
        end
    end

    assign q_o        = q;
    assign left_o     = q[0];
    assign right_o    = q[N-1];
    assign right_oe_o = (dir_i == DIR_LR);
    assign left_oe_o  = (dir_i != DIR_LR);

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (q == '0))
        else $error("shift register not cleared by reset");

    p_shift_lr_r2: assert property (@(posedge clk) disable iff (rst)
        (step_i && dir_i == DIR_LR) |=> (q == {$past(q[N-2:0]), $past(left_i)}))
        else $error("left-to-right shift wrong");

    p_shift_rl_r2: assert property (@(posedge clk) disable iff (rst)
        (step_i && dir_i == DIR_RL) |=> (q == {$past(right_i), $past(q[N-1:1])}))
        else $error("right-to-left shift wrong");

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(q))
        else $error("shift register moved without a shift event");

endmodule

// File: rtl/lcd_out_latch.sv
module lcd_out_latch
    import lcd_drv_pkg::*;
#(
    parameter int unsigned N = CH_OUTS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic [N-1:0]   d_i,
    input  logic           pol_i,
    output logic [N-1:0]   sel_o,
    output logic [2*N-1:0] code_o
);
    logic [N-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst)         lat_q <= '0;
        else if (load_i) lat_q <= d_i;
    end

    assign sel_o = lat_q;

    for (genvar i = 0; i < N; i++) begin : g_enc
        lvl_code_t c;
        assign c              = encode_level(lat_q[i], pol_i);
        assign code_o[2*i+:2] = c;
    end

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (lat_q == $past(d_i)))
        else $error("latch did not capture register");

    p_keep_r4: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(lat_q))
        else $error("latch changed without a load event");

endmodule

// File: rtl/lcd_serial_drv.sv
module lcd_serial_drv
    import lcd_drv_pkg::*;
#(
    parameter int unsigned N = CH_OUTS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_clk_i,
    input  logic           latch_clk_i,
    input  logic           m_i,
    input  logic           bypass_i,
    input  logic [1:0]     dir_i,
    input  logic [1:0]     left_i,
    input  logic [1:0]     right_i,
    output logic [1:0]     left_o,
    output logic [1:0]     right_o,
    output logic [1:0]     left_oe_o,
    output logic [1:0]     right_oe_o,
    output logic [2*N-1:0] ch1_code_o,
    output logic [2*N-1:0] ch2_code_o
);
    logic [STB_W-1:0] stb, rise, fall;
    ch_ctl_t          ctl   [NUM_CH];
    logic [2*N-1:0]   codes [NUM_CH];
    logic [N-1:0]     sel   [NUM_CH];

    assign stb[STB_SHIFT] = shift_clk_i;
    assign stb[STB_LATCH] = latch_clk_i;

    lcd_edge_det #(.W(STB_W)) i_edges (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (stb),
        .rise_o (rise),
        .fall_o (fall)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [N-1:0] q;

        // channel 2 in bypass mode swaps strobes, uses rising edges, inverts M
        if (c == 1) begin : g_scan_cap
            always_comb begin
                if (bypass_i) begin
                    ctl[c].shift   = rise[STB_LATCH];
                    ctl[c].load    = rise[STB_SHIFT];
                    ctl[c].pol_inv = 1'b1;
                end else begin
                    ctl[c].shift   = fall[STB_SHIFT];
                    ctl[c].load    = fall[STB_LATCH];
                    ctl[c].pol_inv = 1'b0;
                end
            end
        end else begin : g_seg_only
            always_comb begin
                ctl[c].shift   = fall[STB_SHIFT];
                ctl[c].load    = fall[STB_LATCH];
                ctl[c].pol_inv = 1'b0;
            end
        end

        lcd_shift_reg #(.N(N)) i_sr (
            .clk        (clk),
            .rst        (rst),
            .step_i     (ctl[c].shift),
            .dir_i      (dir_i[c]),
            .left_i     (left_i[c]),
            .right_i    (right_i[c]),
            .q_o        (q),
            .left_o     (left_o[c]),
            .right_o    (right_o[c]),
            .left_oe_o  (left_oe_o[c]),
            .right_oe_o (right_oe_o[c])
        );

        lcd_out_latch #(.N(N)) i_lat (
            .clk    (clk),
            .rst    (rst),
            .load_i (ctl[c].load),
            .d_i    (q),
            .pol_i  (m_i ^ ctl[c].pol_inv),
            .sel_o  (sel[c]),
            .code_o (codes[c])
        );
    end

    assign ch1_code_o = codes[0];
    assign ch2_code_o = codes[1];

    p_byp_fall_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (bypass_i && fall[STB_SHIFT]) |=> $stable(sel[1]))
        else $error("channel 2 latched on a falling edge in bypass mode");

endmodule

// File: tb/test_lcd_serial_drv.sv
module test_lcd_serial_drv;
    import lcd_drv_pkg::*;

    localparam int N = CH_OUTS;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           shift_clk = 1'b0, latch_clk = 1'b0, m = 1'b0, byp = 1'b0;
    logic [1:0]     dir = 2'b11, lin = '0, rin = '0;
    logic [1:0]     lout, rout, loe, roe;
    logic [2*N-1:0] c1, c2;

    logic [N-1:0] msr [2];
    logic [N-1:0] mlt [2];
    int nchecks = 0;
    int nerr    = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    lcd_serial_drv i_lcd_serial_drv (
        .clk(clk), .rst(rst), .shift_clk_i(shift_clk), .latch_clk_i(latch_clk),
        .m_i(m), .bypass_i(byp), .dir_i(dir), .left_i(lin), .right_i(rin),
        .left_o(lout), .right_o(rout), .left_oe_o(loe), .right_oe_o(roe),
        .ch1_code_o(c1), .ch2_code_o(c2)
    );

    function automatic logic [2*N-1:0] exp_code(logic [N-1:0] lat, logic pol);
        logic [2*N-1:0] r;
        for (int i = 0; i < N; i++) begin
            r[2*i+1] = lat[i];
            r[2*i]   = pol;
        end
        return r;
    endfunction

    function automatic logic [N-1:0] exp_shift(logic [N-1:0] q, logic d, logic l, logic r);
        return d ? {q[N-2:0], l} : {r, q[N-1:1]};
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] got, logic [63:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int c = 0; c < 2; c++) begin
            logic [2*N-1:0] e, g;
            logic pol;
            pol = m ^ ((c == 1) && byp);
            e = exp_code(mlt[c], pol);
            g = (c == 0) ? c1 : c2;
            chk(g === e, {tag, " R6 codes"}, 64'(g), 64'(e));
            chk({loe[c], roe[c]} === {~dir[c], dir[c]}, {tag, " R7 oe"},
                64'({loe[c], roe[c]}), 64'({~dir[c], dir[c]}));
            if (dir[c]) chk(rout[c] === msr[c][N-1], {tag, " R7 cascade right"},
                            64'(rout[c]), 64'(msr[c][N-1]));
            else        chk(lout[c] === msr[c][0], {tag, " R7 cascade left"},
                            64'(lout[c]), 64'(msr[c][0]));
        end
    endtask

    // change one strobe level; update the model; wait for the DUT to respond
    task automatic strobe(bit which_latch, logic val, string tag);
        logic old;
        bit sh [2];
        bit ld [2];
        old = which_latch ? latch_clk : shift_clk;
        sh = '{0, 0};
        ld = '{0, 0};
        if (old != val) begin
            if (!which_latch && !val) begin sh[0] = 1; if (!byp) sh[1] = 1; end
            if (!which_latch &&  val && byp) ld[1] = 1;
            if ( which_latch && !val) begin ld[0] = 1; if (!byp) ld[1] = 1; end
            if ( which_latch &&  val && byp) sh[1] = 1;
        end
        for (int c = 0; c < 2; c++) begin
            if (ld[c]) mlt[c] = msr[c];
            if (sh[c]) msr[c] = exp_shift(msr[c], dir[c], lin[c], rin[c]);
        end
        if (which_latch) latch_clk = val; else shift_clk = val;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; shift_clk = 1'b0; latch_clk = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        msr = '{default: '0};
        mlt = '{default: '0};
        @(negedge clk);
    endtask

    function automatic int sel_count(logic [2*N-1:0] v);
        int n = 0;
        for (int i = 0; i < N; i++) n += v[2*i+1];
        return n;
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        do_reset();
        // R1 reset state, both polarities of M
        for (int k = 0; k < 2; k++) begin
            m = k[0];
            @(negedge clk);
            check_all("R1 reset");
            chk(sel_count(c1) + sel_count(c2) == 0, "R1 no selected", 64'(sel_count(c1)), 0);
        end

        // R2 R3 R4: normal mode, both directions, random data
        for (int pass = 0; pass < 4; pass++) begin
            byp = 1'b0;
            dir = pass[1:0];
            for (int b = 0; b < N; b++) begin
                lin = 2'($urandom()); rin = 2'($urandom()); m = 1'($urandom());
                strobe(0, 1'b1, "R3 shift rise");
                strobe(0, 1'b0, "R3 shift fall");
            end
            strobe(1, 1'b1, "R4 latch rise");
            strobe(1, 1'b0, "R4 latch fall");
            chk(c1[2*N-1:0] === exp_code(msr[0], m), "R2 ch1 pattern", 64'(c1), 64'(exp_code(msr[0], m)));
        end

        // R5: bypass mode, random strobe activity
        byp = 1'b1;
        for (int k = 0; k < 200; k++) begin
            dir = 2'($urandom()); lin = 2'($urandom()); rin = 2'($urandom());
            m = 1'($urandom());
            if ($urandom() % 2) strobe(0, ~shift_clk, "R5 bypass shift strobe");
            else                strobe(1, ~latch_clk, "R5 bypass latch strobe");
        end

        // R8: scan walk, both directions
        for (int d = 0; d < 2; d++) begin
            do_reset();
            byp = 1'b1;
            dir = {d[0], 1'b1};
            for (int k = 0; k < N + 2; k++) begin
                lin = {(k == 0) ? 1'b1 : 1'b0, 1'($urandom())};
                rin = {(k == 0) ? 1'b1 : 1'b0, 1'($urandom())};
                strobe(1, 1'b1, "R8 scan shift");
                strobe(1, 1'b0, "R8 latch fall");
                strobe(0, 1'b1, "R8 scan latch");
                strobe(0, 1'b0, "R8 shift fall");
                chk(sel_count(c2) == ((k < N) ? 1 : 0), "R8 one scan line",
                    64'(sel_count(c2)), 64'((k < N) ? 1 : 0));
            end
        end

        // mixed random, including mode changes
        for (int k = 0; k < 400; k++) begin
            dir = 2'($urandom()); lin = 2'($urandom()); rin = 2'($urandom());
            m = 1'($urandom());
            if ($urandom() % 16 == 0) byp = ~byp;
            if ($urandom() % 2) strobe(0, ~shift_clk, "R3 R5 mixed shift strobe");
            else                strobe(1, ~latch_clk, "R4 R5 mixed latch strobe");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            nchecks++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

endmodule